// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between the instruction decode stage of a 32-bit core and a simple memory port. It takes one instruction word together with the values of its two source registers. It recognises the load and store encodings and forms the effective address as register A plus a sign-extended 16-bit offset. It then issues one memory request that carries byte enables and store data already placed in the addressed lanes of a big-endian bus. When a load response returns, the block selects the addressed byte or halfword, zero- or sign-extends it, and presents it for writeback to the destination register.

Only one access is in flight at a time. The block keeps the access size, the extension mode and the two low address bits until the response arrives. A new instruction can be accepted in the same cycle as a response. A sub-word access that breaks its natural alignment raises a one-cycle flag and is not sent to memory. Instructions that are not loads or stores are accepted and dropped.

Top module: `lsu_lane_unit`

## Requirements
- R1: An instruction with bits 31..30 = 2 and bits 29..26 in 0..4 is a load: 0 word, 1 byte zero-extended, 2 byte sign-extended, 3 halfword zero-extended, 4 halfword sign-extended. It issues a read (`mem_req_we`=0) whose address is register A plus the sign-extended bits 15..0.
- R2: An instruction with bits 31..30 = 3 and bits 29..26 = 5 (word), 6 (byte) or 7 (halfword) is a store (`mem_req_we`=1). Its offset is rebuilt as {bits 25..21, bits 10..0}, sign-extended and added to register A. `src_a_idx` carries bits 20..16 and `src_b_idx` carries bits 15..11 for every instruction.
- R3: Byte enables are big-endian, where enable bit 3 covers data bits 31..24 (the lowest address). A byte access sets bit 3 minus the address modulo 4. A halfword sets bits 3..2 for address bit 1 = 0 and bits 1..0 otherwise. A word sets all four bits.
- R4: Store data is register B for words, its low halfword repeated twice for halfwords, and its low byte repeated four times for bytes.
- R5: In the response cycle of a load, `wb_valid` is 1, `wb_idx` equals instruction bits 25..21, and `wb_data` holds the addressed lane (the lowest address in the most significant position), zero- or sign-extended as the opcode selects.
- R6: A halfword at an odd address, or a word whose address has either low bit set, issues no request. `misalign_flag` is high for exactly the cycle after acceptance, and the block is ready again in that cycle.
- R7: While a request waits for `mem_req_ready`, the request stays valid and its address, enables and data stay stable. `issue_ready` is low from acceptance until the response cycle.
- R8: `issue_ready` is high in the response cycle, so an instruction accepted there is issued as a request in the next cycle, while the old response is written back in the current cycle.
- R9: An instruction that matches neither the load nor the store encodings is accepted but issues no request, raises no flag and produces no writeback.
- R10: The response to a store ends the access without a writeback (`wb_valid` stays 0).
- R11: After reset, `issue_ready` is 1 and `mem_req_valid`, `wb_valid` and `misalign_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Instruction can be accepted |
| instr | input | 32 | Instruction word |
| src_a_idx | output | 5 | Base register index (bits 20..16) |
| src_b_idx | output | 5 | Store data register index (bits 15..11) |
| rega_val | input | ADDR_W | Base register value |
| regb_val | input | 32 | Store data register value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 for store, 0 for load |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_be | output | 4 | Lane enables, bit 3 = bits 31..24 |
| mem_req_wdata | output | 32 | Lane-placed store data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | 32 | Read data word |
| wb_valid | output | 1 | Load result valid |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Extended load result |
| misalign_flag | output | 1 | Misaligned access dropped |

## Verification
The response cycle of a load and the acceptance of the next instruction can fall in the same cycle. This is the one place where the held lane state is overwritten while it still selects the returned data. The bench drives a new store or a misaligned access together with a load response. It checks that the writeback in that cycle is extracted with the old size and address bits, and that in the next cycle the new request, or the misalignment flag, reflects only the new instruction. Full sweeps over opcode, low address bits, offset sign and data pattern cover the lane logic around this overlap.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int LANES   = 4;
  localparam int DATA_W  = 8 * LANES;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic        is_load;
    logic        is_store;
    acc_size_e   size;
    logic        sext;
    logic [4:0]  dst;
    logic [4:0]  src_a;
    logic [4:0]  src_b;
    logic [15:0] offset;
  } mem_op_t;

  // Lane enables, bit 3 is the lowest address (bits 31..24).
  function automatic logic [LANES-1:0] lane_enables(acc_size_e sz, logic [1:0] lo);
    case (sz)
      ACC_BYTE: return 4'b1000 >> lo;
      ACC_HALF: return lo[1] ? 4'b0011 : 4'b1100;
      default:  return 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] align_store(acc_size_e sz, logic [DATA_W-1:0] d);
    case (sz)
      ACC_BYTE: return {4{d[7:0]}};
      ACC_HALF: return {2{d[15:0]}};
      default:  return d;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pick_load(acc_size_e sz, logic sx, logic [1:0] lo,
                                                  logic [DATA_W-1:0] rd);
    logic [7:0]  b;
    logic [15:0] h;
    b = 8'(rd >> {~lo, 3'b000});
    h = lo[1] ? rd[15:0] : rd[31:16];
    case (sz)
      ACC_BYTE: return sx ? {{24{b[7]}}, b} : {24'd0, b};
      ACC_HALF: return sx ? {{16{h[15]}}, h} : {16'd0, h};
      default:  return rd;
    endcase
  endfunction

  function automatic logic is_misaligned(acc_size_e sz, logic [1:0] lo);
    case (sz)
      ACC_HALF: return lo[0];
      ACC_WORD: return |lo;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] base,
  output mem_op_t           op,
  output logic [ADDR_W-1:0] eff_addr
);

  logic [1:0] cls;
  logic [3:0] sub;

  assign cls = instr[31:30];
  assign sub = instr[29:26];

  always_comb begin
    op          = '0;
    op.dst      = instr[25:21];
    op.src_a    = instr[20:16];
    op.src_b    = instr[15:11];
    op.size     = ACC_WORD;
    if (cls == 2'd2) begin
      op.offset = instr[15:0];
      case (sub)
        4'd0: begin op.is_load = 1'b1; op.size = ACC_WORD; end
        4'd1: begin op.is_load = 1'b1; op.size = ACC_BYTE; end
        4'd2: begin op.is_load = 1'b1; op.size = ACC_BYTE; op.sext = 1'b1; end
        4'd3: begin op.is_load = 1'b1; op.size = ACC_HALF; end
        4'd4: begin op.is_load = 1'b1; op.size = ACC_HALF; op.sext = 1'b1; end
        default: ;
      endcase
    end else if (cls == 2'd3) begin
      op.offset = {instr[25:21], instr[10:0]};
      case (sub)
        4'd5: begin op.is_store = 1'b1; op.size = ACC_WORD; end
        4'd6: begin op.is_store = 1'b1; op.size = ACC_BYTE; end
        4'd7: begin op.is_store = 1'b1; op.size = ACC_HALF; end
        default: ;
      endcase
    end
  end

  assign eff_addr = base + {{(ADDR_W-16){op.offset[15]}}, op.offset};

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
(
  input  acc_size_e         size,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);

  assign be    = lane_enables(size, lo);
  assign wdata = align_store(size, src);

endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes
  import lsu_pkg::*;
(
  input  acc_size_e         size,
  input  logic              sext,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);

  assign result = pick_load(size, sext, lo, rdata);

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [31:0]       instr,
  output logic [4:0]        src_a_idx,
  output logic [4:0]        src_b_idx,
  input  logic [ADDR_W-1:0] rega_val,
  input  logic [31:0]       regb_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [3:0]        mem_req_be,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              wb_valid,
  output logic [4:0]        wb_idx,
  output logic [31:0]       wb_data,
  output logic              misalign_flag
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} lsu_state_e;

  lsu_state_e        state_q, state_d;
  mem_op_t           op;
  logic [ADDR_W-1:0] ea;
  logic [3:0]        be_new;
  logic [31:0]       wdata_new;
  logic              accept, op_mem, op_bad_align, launch, rsp_done;

  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        be_q;
  logic [31:0]       wdata_q;
  logic              we_q, sext_q, mis_q;
  acc_size_e         size_q;
  logic [4:0]        dst_q;

  lsu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .instr    (instr),
    .base     (rega_val),
    .op       (op),
    .eff_addr (ea)
  );

  lsu_store_lanes u_st (
    .size  (op.size),
    .lo    (ea[1:0]),
    .src   (regb_val),
    .be    (be_new),
    .wdata (wdata_new)
  );

  lsu_load_lanes u_ld (
    .size   (size_q),
    .sext   (sext_q),
    .lo     (addr_q[1:0]),
    .rdata  (mem_rsp_rdata),
    .result (wb_data)
  );

  // Named internal events.
  assign rsp_done     = (state_q == ST_WAIT) && mem_rsp_valid;
  assign issue_ready  = (state_q == ST_IDLE) || rsp_done;
  assign accept       = issue_valid && issue_ready;
  assign op_mem       = op.is_load || op.is_store;
  assign op_bad_align = is_misaligned(op.size, ea[1:0]);
  assign launch       = accept && op_mem && !op_bad_align;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_REQ;
      ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_d = launch ? ST_REQ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      sext_q  <= 1'b0;
      size_q  <= ACC_WORD;
      dst_q   <= '0;
      mis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mis_q   <= accept && op_mem && op_bad_align;
      if (launch) begin
        addr_q  <= ea;
        be_q    <= be_new;
        wdata_q <= wdata_new;
        we_q    <= op.is_store;
        sext_q  <= op.sext;
        size_q  <= op.size;
        dst_q   <= op.dst;
      end
    end
  end

  assign src_a_idx     = op.src_a;
  assign src_b_idx     = op.src_b;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_we    = we_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_be    = be_q;
  assign mem_req_wdata = wdata_q;
  assign wb_valid      = rsp_done && !we_q;
  assign wb_idx        = dst_q;
  assign misalign_flag = mis_q;

  // Assertions
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_be) && $stable(mem_req_wdata));

  assert_busy_no_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !issue_ready);

  assert_flag_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_flag |-> !mem_req_valid && issue_ready);

  assert_req_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (mem_req_be == 4'b1111) |-> mem_req_addr[1:0] == 2'b00);

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $countones(mem_req_be) inside {1, 2, 4});

  assert_store_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !mem_req_we && mem_rsp_valid);

endmodule

// File: tb/sim_lsu_lane_unit.sv
module sim_lsu_lane_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] instr = '0;
  logic [4:0]  src_a_idx, src_b_idx;
  logic [31:0] rega_val = '0;
  logic [31:0] regb_val = '0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        wb_valid, misalign_flag;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lsu_lane_unit u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ld(int sub, int rd, int ra, logic [15:0] imm);
    return {2'd2, 4'(sub), 5'(rd), 5'(ra), imm};
  endfunction

  function automatic logic [31:0] mk_st(int sub, int ra, int rb, logic [15:0] off);
    return {2'd3, 4'(sub), off[15:11], 5'(ra), 5'(rb), off[10:0]};
  endfunction

  // Reference model computed from the requirement text.
  function automatic int op_bytes(logic [31:0] ins);
    int s = int'(ins[29:26]);
    if (ins[31:30] == 2'd2) begin
      if (s == 0) return 4;
      if (s == 1 || s == 2) return 1;
      if (s == 3 || s == 4) return 2;
    end else if (ins[31:30] == 2'd3) begin
      if (s == 5) return 4;
      if (s == 6) return 1;
      if (s == 7) return 2;
    end
    return 0;
  endfunction

  function automatic logic [31:0] ref_ea(logic [31:0] ins, logic [31:0] a);
    logic [15:0] off;
    off = (ins[31:30] == 2'd3) ? {ins[25:21], ins[10:0]} : ins[15:0];
    return a + 32'($signed(off));
  endfunction

  function automatic logic [3:0] ref_be(int n, logic [31:0] ea);
    logic [3:0] r = '0;
    for (int k = 0; k < n; k++) r[3 - (int'(ea[1:0]) + k)] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] ref_wdata(int n, logic [31:0] b);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) begin
      int m = j % n;
      r[31-8*j -: 8] = 8'((b >> (8 * (n - 1 - m))) & 32'hff);
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_load(int n, bit sx, logic [31:0] ea, logic [31:0] rd);
    logic [31:0] v = '0;
    for (int m = 0; m < n; m++)
      v = (v << 8) | ((rd >> (8 * (3 - (int'(ea[1:0]) + m)))) & 32'hff);
    if (sx && n < 4 && v[8*n-1]) v = v | ~((32'd1 << (8 * n)) - 1);
    return v;
  endfunction

  // One access: offer, check request, answer.
  task automatic run_op(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] rd, input bit stall);
    int n;
    bit is_ld, mis, sx;
    logic [31:0] ea;
    n = op_bytes(ins);
    is_ld = (ins[31:30] == 2'd2);
    sx = is_ld && (ins[29:26] == 4'd2 || ins[29:26] == 4'd4);
    ea = ref_ea(ins, a);
    mis = (n != 0) && ((int'(ea[1:0]) % n) != 0);
    @(negedge clk);
    instr = ins; rega_val = a; regb_val = b; issue_valid = 1'b1;
    #1;
    check(src_a_idx == ins[20:16] && src_b_idx == ins[15:11], "R2 src idx",
          {22'd0, src_a_idx, src_b_idx}, {22'd0, ins[20:16], ins[15:11]});
    @(negedge clk);
    issue_valid = 1'b0;
    if (n == 0 || mis) begin
      check(mem_req_valid == 1'b0, n == 0 ? "R9 no request" : "R6 no request",
            32'(mem_req_valid), 0);
      check(misalign_flag == mis, n == 0 ? "R9 no flag" : "R6 flag",
            32'(misalign_flag), 32'(mis));
      check(issue_ready == 1'b1, "R6 ready after drop", 32'(issue_ready), 1);
      @(negedge clk);
      check(misalign_flag == 1'b0 && wb_valid == 1'b0, "R6 flag one cycle",
            32'(misalign_flag), 0);
      return;
    end
    check(mem_req_valid == 1'b1, "R1 request valid", 32'(mem_req_valid), 1);
    check(mem_req_we == !is_ld, is_ld ? "R1 read" : "R2 write", 32'(mem_req_we), 32'(!is_ld));
    check(mem_req_addr == ea, is_ld ? "R1 address" : "R2 address", mem_req_addr, ea);
    check(mem_req_be == ref_be(n, ea), "R3 enables", 32'(mem_req_be), 32'(ref_be(n, ea)));
    if (!is_ld)
      check(mem_req_wdata == ref_wdata(n, b), "R4 store data", mem_req_wdata, ref_wdata(n, b));
    check(issue_ready == 1'b0, "R7 busy", 32'(issue_ready), 0);
    if (stall) begin
      @(negedge clk);
      check(mem_req_valid == 1'b1 && mem_req_addr == ea, "R7 held under stall",
            mem_req_addr, ea);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(mem_req_valid == 1'b0 && issue_ready == 1'b0, "R7 waiting",
          32'(issue_ready), 0);
    mem_rsp_valid = 1'b1; mem_rsp_rdata = rd;
    #1;
    check(issue_ready == 1'b1, "R8 ready in response cycle", 32'(issue_ready), 1);
    if (is_ld) begin
      check(wb_valid == 1'b1, "R5 wb valid", 32'(wb_valid), 1);
      check(wb_idx == ins[25:21], "R5 wb index", 32'(wb_idx), 32'(ins[25:21]));
      check(wb_data == ref_load(n, sx, ea, rd), "R5 wb data", wb_data, ref_load(n, sx, ea, rd));
    end else begin
      check(wb_valid == 1'b0, "R10 store no wb", 32'(wb_valid), 0);
    end
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    logic [31:0] ea, ld_ins, st_ins;
    pats[0] = 32'h8192_A3F4;
    pats[1] = 32'h7E6D_5C4B;
    pats[2] = 32'hFF00_80_7F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(issue_ready == 1'b1, "R11 ready", 32'(issue_ready), 1);
    check(!mem_req_valid && !wb_valid && !misalign_flag, "R11 idle outputs",
          {29'd0, mem_req_valid, wb_valid, misalign_flag}, 0);

    // Loads: every opcode, every low address, both offset signs, two data patterns.
    for (int s = 0; s <= 4; s++)
      for (int lo = 0; lo < 4; lo++)
        for (int sg = 0; sg < 2; sg++)
          for (int p = 0; p < 2; p++)
            run_op(mk_ld(s, (s * 7 + lo) % 32, 3, sg ? 16'hFFF8 : 16'h0104),
                   32'h0000_1000 + 32'(lo), 32'h0, pats[p + (s % 2)], (lo == 1 && p == 0));

    // Stores: every opcode, low address, offset sign.
    for (int s = 5; s <= 7; s++)
      for (int lo = 0; lo < 4; lo++)
        for (int sg = 0; sg < 2; sg++)
          run_op(mk_st(s, 4, 9, sg ? 16'hC7F0 : 16'h3A18), 32'h0002_0000 + 32'(lo),
                 pats[sg], 32'h0, (lo == 2));

    // Non-memory encodings are dropped.
    run_op({2'd2, 4'd5, 26'h123_4567}, 32'h100, 32'h0, 32'h0, 0);
    run_op({2'd3, 4'd4, 26'h000_0000}, 32'h100, 32'h0, 32'h0, 0);
    run_op({2'd0, 4'd0, 26'h3FF_FFFF}, 32'h100, 32'h0, 32'h0, 0);
    run_op({2'd1, 4'd9, 26'h0AB_CDEF}, 32'h100, 32'h0, 32'h0, 0);

    // Overlap: response of a signed byte load with acceptance of a halfword store.
    ld_ins = mk_ld(2, 17, 1, 16'h0003);
    st_ins = mk_st(7, 2, 5, 16'hFFFE);
    @(negedge clk);
    instr = ld_ins; rega_val = 32'h400; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0; mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_rdata = 32'h1122_33C5;
    instr = st_ins; rega_val = 32'h802; regb_val = 32'hDEAD_BEEF; issue_valid = 1'b1;
    #1;
    check(issue_ready && wb_valid, "R8 overlap ready and wb", {30'd0, issue_ready, wb_valid}, 3);
    check(wb_data == 32'hFFFF_FFC5 && wb_idx == 5'd17, "R8 old lane used", wb_data, 32'hFFFF_FFC5);
    @(negedge clk);
    issue_valid = 1'b0; mem_rsp_valid = 1'b0;
    ea = 32'h800;
    check(mem_req_valid && mem_req_we && mem_req_addr == ea, "R8 new request", mem_req_addr, ea);
    check(mem_req_be == 4'b1100 && mem_req_wdata == 32'hBEEF_BEEF, "R8 new lanes",
          mem_req_wdata, 32'hBEEF_BEEF);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b1;
    #1;
    check(wb_valid == 1'b0, "R10 overlap store no wb", 32'(wb_valid), 0);
    @(negedge clk);
    mem_rsp_valid = 1'b0;

    // Overlap: response of a word load with acceptance of a misaligned word.
    @(negedge clk);
    instr = mk_ld(0, 8, 1, 16'h0000); rega_val = 32'h500; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0; mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b1; mem_rsp_rdata = 32'hCAFE_0123;
    instr = mk_ld(0, 9, 1, 16'h0002); issue_valid = 1'b1;
    #1;
    check(wb_valid && wb_data == 32'hCAFE_0123, "R8 word wb in overlap", wb_data, 32'hCAFE_0123);
    @(negedge clk);
    issue_valid = 1'b0; mem_rsp_valid = 1'b0;
    check(misalign_flag == 1'b1 && mem_req_valid == 1'b0, "R6 flag after overlap",
          {30'd0, misalign_flag, mem_req_valid}, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule